// File: doc/BRIEF.md
# Timer interrupt mask and status unit

This block gathers the event sources of a timer peripheral and turns them into interrupt requests. Seven sources are handled: a counter overflow strobe, two alarm match strobes, two periodic taps taken from a free-running prescaler value, a clock-ready event and a synchronisation-ready event. Each source owns one bit of a sticky status register and one bit of a mask register. Requests go out both per source and as one combined line.

The periodic taps watch a software-chosen bit of the prescaler and fire when that bit rises. The two ready events fire when the clock-busy or sync-busy flag falls. Software changes the mask through separate set and clear ports, and removes status bits through a clear port. Each of these ports acts on every bit written as one in a given cycle.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the status register, mask register, per-source requests and combined interrupt are all zero.
- R2: Source bit order is 0 overflow, 1 and 2 periodic taps 0 and 1, 3 and 4 alarms 0 and 1, 5 clock-ready, 6 sync-ready. A high overflow or alarm strobe at a clock edge sets its status bit at that edge.
- R3: Each periodic tap has a 5-bit selector choosing one of 32 prescaler bits. Its status bit is set at an edge where the selected bit is one and the value sampled through the selector at the previous edge was zero.
- R4: Status bit 5 is set at an edge where the clock-busy flag is zero and was one at the previous edge.
- R5: Status bit 6 is set at an edge where the sync-busy flag is zero and was one at the previous edge.
- R6: A one on a bit of the mask-set port sets that mask bit, and a one on the mask-clear port clears it. When both hit the same bit in one cycle, the bit ends up set.
- R7: The per-source request for a bit is one exactly while both its status bit and its mask bit are one.
- R8: A status bit stays set until a one is written to the matching bit of the status-clear port. A set event and a clear on the same bit in the same cycle leave the bit set.
- R9: The combined interrupt equals the OR of all per-source requests, delayed by one clock.
- R10: At the first edge after reset no edge event is detected, even when a selected prescaler bit is already one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt | input | 1 | Counter overflow strobe |
| alm_evt | input | 2 | Alarm match strobes |
| presc_val | input | 32 | Prescaler value |
| per_sel | input | 10 | Tap selectors, 5 bits per tap, tap 0 in the low bits |
| clk_busy | input | 1 | Clock synchronisation busy flag |
| sync_busy | input | 1 | Register synchronisation busy flag |
| mask_set | input | 7 | Write-one-to-set mask port |
| mask_clr | input | 7 | Write-one-to-clear mask port |
| stat_clr | input | 7 | Write-one-to-clear status port |
| status | output | 7 | Status register |
| mask | output | 7 | Mask register |
| req | output | 7 | Per-source masked requests |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench targets simultaneous set and clear on the same status or mask bit. A design that lets the clear win there drops an event or a mask bit. Selector changes in mid-run are also exercised, because the tap edge is measured against the value sampled through the selector. A design that keeps the raw prescaler history would then fire on the wrong cycles. Reset with the selected prescaler bits already high catches a spurious periodic event. Long runs without clears catch a status bit that decays by itself, and comparing the combined line one cycle late catches an unregistered or mistimed interrupt.

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
  parameter int PRESC_W = 32,
  parameter int N_PER   = 2,
  parameter int N_ALM   = 2,
  localparam int SEL_W  = $clog2(PRESC_W),
  localparam int ALM_LO = 1 + N_PER,
  localparam int CRDY   = ALM_LO + N_ALM,
  localparam int SRDY   = CRDY + 1,
  localparam int NSRC   = SRDY + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ovf_evt,
  input  logic [N_ALM-1:0]       alm_evt,
  input  logic [PRESC_W-1:0]     presc_val,
  input  logic [N_PER*SEL_W-1:0] per_sel,
  input  logic                   clk_busy,
  input  logic                   sync_busy,
  input  logic [NSRC-1:0]        mask_set,
  input  logic [NSRC-1:0]        mask_clr,
  input  logic [NSRC-1:0]        stat_clr,
  output logic [NSRC-1:0]        status,
  output logic [NSRC-1:0]        mask,
  output logic [NSRC-1:0]        req,
  output logic                   irq
);

  logic [N_PER-1:0] tap_now, tap_prev, per_hit;
  logic             cb_prev, sb_prev;
  logic [NSRC-1:0]  set_vec, status_q, mask_q;
  logic             irq_q;

  for (genvar g = 0; g < N_PER; g++) begin : g_tap
    assign tap_now[g] = presc_val[per_sel[g*SEL_W +: SEL_W]];
  end

  assign per_hit = tap_now & ~tap_prev;
  assign set_vec = {~sync_busy & sb_prev, ~clk_busy & cb_prev, alm_evt, per_hit, ovf_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_prev <= '1;
      cb_prev  <= 1'b0;
      sb_prev  <= 1'b0;
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      tap_prev <= tap_now;
      cb_prev  <= clk_busy;
      sb_prev  <= sync_busy;
      status_q <= (status_q & ~stat_clr) | set_vec;
      mask_q   <= (mask_q & ~mask_clr) | mask_set;
      irq_q    <= |(status_q & mask_q);
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign req    = status_q & mask_q;
  assign irq    = irq_q;

  TIU_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status[0]); // R2
  TIU_ALM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    |alm_evt |=> ((status[CRDY-1:ALM_LO] & $past(alm_evt)) == $past(alm_evt))); // R2
  TIU_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(stat_clr)) & ~status) == '0)); // R8
  TIU_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    |mask_set |=> (($past(mask_set) & ~mask) == '0)); // R6
  TIU_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    |mask_clr |=> (($past(mask_clr & ~mask_set) & mask) == '0)); // R6
  TIU_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~mask) == '0); // R7
  TIU_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    |req |=> irq); // R9
  TIU_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |=> !irq); // R9

endmodule

// File: tb/tb_tmr_irq_unit.sv
`timescale 1ns/1ps
module tb_tmr_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ovf_evt;
  logic [1:0]  alm_evt;
  logic [31:0] presc_val;
  logic [9:0]  per_sel;
  logic        clk_busy, sync_busy;
  logic [6:0]  mask_set, mask_clr, stat_clr;
  logic [6:0]  status, mask, req;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [6:0] m_st, m_mk;
  logic       m_irq;
  logic [1:0] m_tp;
  logic       m_cb, m_sb;

  always #5 clk = ~clk;

  tmr_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .alm_evt(alm_evt),
    .presc_val(presc_val), .per_sel(per_sel), .clk_busy(clk_busy),
    .sync_busy(sync_busy), .mask_set(mask_set), .mask_clr(mask_clr),
    .stat_clr(stat_clr), .status(status), .mask(mask), .req(req), .irq(irq)
  );

  function automatic logic [1:0] taps(input logic [31:0] p, input logic [9:0] s);
    return {p[s[9:5]], p[s[4:0]]};
  endfunction

  function automatic logic [6:0] set_of(input logic [1:0] tn);
    return {~sync_busy & m_sb, ~clk_busy & m_cb, alm_evt, tn & ~m_tp, ovf_evt};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ovf_evt = 0; alm_evt = 0; mask_set = 0; mask_clr = 0; stat_clr = 0;
  endtask

  task automatic compare_all();
    chk("R2 ovf/alarm status", {25'd0, status & 7'b0011001}, {25'd0, m_st & 7'b0011001});
    chk("R3 periodic status",  {25'd0, status & 7'b0000110}, {25'd0, m_st & 7'b0000110});
    chk("R4 clock-ready",      {31'd0, status[5]}, {31'd0, m_st[5]});
    chk("R5 sync-ready",       {31'd0, status[6]}, {31'd0, m_st[6]});
    chk("R6 mask",             {25'd0, mask}, {25'd0, m_mk});
    chk("R7 requests",         {25'd0, req}, {25'd0, m_st & m_mk});
    chk("R9 combined irq",     {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic step();
    logic [1:0] tn;
    tn = taps(presc_val, per_sel);
    m_irq = |(m_st & m_mk);
    m_st  = (m_st & ~stat_clr) | set_of(tn);
    m_mk  = (m_mk & ~mask_clr) | mask_set;
    m_tp  = tn;
    m_cb  = clk_busy;
    m_sb  = sync_busy;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; idle_inputs();
    presc_val = '1; per_sel = {5'd31, 5'd0};
    clk_busy = 0; sync_busy = 0;
    m_st = 0; m_mk = 0; m_irq = 0; m_tp = 2'b11; m_cb = 0; m_sb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset status", {25'd0, status}, 32'd0);
    chk("R1 reset mask",   {25'd0, mask}, 32'd0);
    chk("R1 reset req",    {25'd0, req}, 32'd0);
    chk("R1 reset irq",    {31'd0, irq}, 32'd0);
    step();
    chk("R10 no tap event after reset", {30'd0, status[2:1]}, 32'd0);
    presc_val = 0;
    step();

    for (int i = 0; i < 4000; i++) begin
      presc_val = presc_val + 32'd1;
      if ($urandom % 64 == 0) per_sel = 10'($urandom);
      ovf_evt  = ($urandom % 16 == 0);
      alm_evt  = {($urandom % 12 == 0), ($urandom % 12 == 0)};
      if ($urandom % 8 == 0) clk_busy  = ~clk_busy;
      if ($urandom % 8 == 0) sync_busy = ~sync_busy;
      mask_set = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
      mask_clr = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
      stat_clr = ($urandom % 3 == 0) ? 7'($urandom) : 7'd0;
      step();
    end

    idle_inputs();
    mask_clr = '1; step();
    mask_clr = 0; stat_clr = '1; step();
    stat_clr = 0;
    ovf_evt = 1; step();
    ovf_evt = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R8 status held without clear", {31'd0, status[0]}, 32'd1);
    end
    ovf_evt = 1; stat_clr = 7'b0000001; step();
    chk("R8 set wins over clear", {31'd0, status[0]}, 32'd1);
    ovf_evt = 0; step();
    chk("R8 clear removes bit", {31'd0, status[0]}, 32'd0);
    stat_clr = 0;
    mask_set = '1; mask_clr = '1; step();
    chk("R6 set wins over clear", {25'd0, mask}, 32'h7F);
    mask_set = 0; mask_clr = 0;
    alm_evt = 2'b10; step();
    alm_evt = 0;
    chk("R7 alarm 1 request", {25'd0, req}, 32'h10);
    step();
    chk("R9 irq one cycle later", {31'd0, irq}, 32'd1);
    clk_busy = 1; sync_busy = 1; step();
    clk_busy = 0; step();
    chk("R4 clock-ready on fall", {31'd0, status[5]}, 32'd1);
    chk("R5 sync-ready not yet", {31'd0, status[6]}, 32'd0);
    sync_busy = 0; step();
    chk("R5 sync-ready on fall", {31'd0, status[6]}, 32'd1);
    per_sel = {5'd7, 5'd3}; presc_val = 0; step();
    presc_val = 32'h0000_0008; step();
    chk("R3 tap 0 rising edge", {30'd0, status[2:1]}, 32'd1);
    presc_val = 32'h0000_0088; step();
    chk("R3 tap 1 rising edge", {30'd0, status[2:1]}, 32'd3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule